// File: doc/BRIEF.md
# Cross-Clock Mailbox Register

This block carries a single data word from a producer running on one clock to a consumer running on an unrelated clock. It works alongside a FIFO but does not pass through it. On the write side, an access that is qualified and has its mailbox select set loads the write bus into a mail register. On the read side, the mailbox select chooses whether the output bus shows the mail register or the FIFO data that arrives from outside the block.

An active-low flag reports that a word is waiting. Each clock domain has its own copy of the flag. A write flips a toggle in the write domain, and that toggle is synchronized into the read domain. A qualified mailbox read flips an acknowledge toggle in the read domain, and that toggle is synchronized back. The write side counts the word as waiting until the acknowledge has arrived. This stops a new word from overwriting the register while the reader may still be sampling it.

Top module: `mbx_bridge`

## Requirements
- R1: A write-clock rising edge with `wr_cs_n`=0, `wr_en`=1, `wr_mbx_sel`=1 and `wr_mail_flag_n`=1 loads `wr_data` into the mail register.
- R2: `wr_mail_flag_n` is 0 right after the edge that performs an R1 write.
- R3: While `wr_mail_flag_n` is 0, a write as in R1 leaves the mail register unchanged.
- R4: A write edge with `wr_cs_n`=1, `wr_en`=0 or `wr_mbx_sel`=0 changes neither the mail register nor either flag.
- R5: `rd_data` equals the mail register while `rd_mbx_sel`=1 and equals `fifo_data` while `rd_mbx_sel`=0, whatever the flag state.
- R6: `rd_mail_flag_n` goes to 0 on the SYNC_STAGES-th read-clock rising edge that follows the write edge, and not before.
- R7: A read-clock rising edge with `rd_cs_n`=0, `rd_en`=1, `rd_mbx_sel`=1 while `rd_mail_flag_n`=0 sets `rd_mail_flag_n` to 1 on that edge.
- R8: A read edge with `rd_mbx_sel`=0, `rd_cs_n`=1 or `rd_en`=0 leaves `rd_mail_flag_n` at 0.
- R9: After an R7 read, `wr_mail_flag_n` returns to 1 only on the SYNC_STAGES-th write-clock rising edge that follows it. A write attempted before that edge is ignored.
- R10: A partial reset (`*_prst_n`=0) or a master reset (`*_rst_n`=0) applied to both domains drives both flags to 1. A master reset also clears the mail register to zero. A partial reset leaves its contents in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side master reset, synchronous, active low |
| wr_prst_n | input | 1 | Write-side partial reset, synchronous, active low |
| wr_cs_n | input | 1 | Write-side chip select, active low |
| wr_en | input | 1 | Write-side enable, active high |
| wr_mbx_sel | input | 1 | Routes a qualified write into the mail register |
| wr_data | input | WIDTH | Write data bus |
| wr_mail_flag_n | output | 1 | Write-domain flag view, 0 = word waiting |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side master reset, synchronous, active low |
| rd_prst_n | input | 1 | Read-side partial reset, synchronous, active low |
| rd_cs_n | input | 1 | Read-side chip select, active low |
| rd_en | input | 1 | Read-side enable, active high |
| rd_mbx_sel | input | 1 | Selects mail data and marks a read as a mailbox read |
| fifo_data | input | WIDTH | FIFO read data, passed through when not selecting mail |
| rd_data | output | WIDTH | Read data bus |
| rd_mail_flag_n | output | 1 | Read-domain flag view, 0 = word waiting |

## Verification
The bench uses the default WIDTH of 36 and SYNC_STAGES of 2. Both clocks run at the same rate, with the read clock offset by 3 ns. That fixed phase makes the synchronizer latency deterministic, so the exact edge on which each flag view changes (R6, R9) can be checked rather than only bounded. Because SYNC_STAGES is 2, the guard window after a read is one write-clock cycle wide. A write can be placed on the last edge of that window, which exercises the early-overwrite case directly.

// File: rtl/mbx_pkg.sv
// Package: shared defaults and the port qualification rule for the mailbox.
// Assumes: nothing; pure constants and functions.
package mbx_pkg;

    localparam int unsigned MBX_WIDTH_DEF = 36;
    localparam int unsigned MBX_SYNC_DEF  = 2;

    // A port access counts only with chip select low and enable high.
    function automatic logic port_qualified(input logic cs_n, input logic en);
        return (!cs_n) && en;
    endfunction

endpackage

// File: rtl/mbx_sync.sv
// Module: multi-flop synchronizer for a single level signal.
// Assumes: d changes at most once per several destination cycles (toggle use);
// STAGES >= 2. clr_n is a synchronous active-low clear in the destination domain.
module mbx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First flop captures the asynchronous input.
            always_ff @(posedge clk) begin
                if (!clr_n) chain[0] <= 1'b0;
                else        chain[0] <= d;
            end
        end else begin : g_next
            // Later flops let metastability settle.
            always_ff @(posedge clk) begin
                if (!clr_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/mbx_wr_port.sv
// Module: write-domain half of the mailbox. Holds the mail register, flips the
// set toggle on each accepted write, and synchronizes the reader's acknowledge.
// Assumes: ack_tog comes from the read domain and is stable between toggles;
// both domains are reset together.
module mbx_wr_port
    import mbx_pkg::*;
#(
    parameter int unsigned WIDTH  = MBX_WIDTH_DEF,
    parameter int unsigned STAGES = MBX_SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prst_n,
    input  logic             cs_n,
    input  logic             en,
    input  logic             mbx_sel,
    input  logic [WIDTH-1:0] data,
    input  logic             ack_tog,
    output logic [WIDTH-1:0] mail_q,
    output logic             set_tog,
    output logic             flag_n
);

    logic clr_n;
    logic ack_seen;
    logic full;
    logic accept;

    assign clr_n = rst_n && prst_n;

    mbx_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk   (clk),
        .clr_n (clr_n),
        .d     (ack_tog),
        .q     (ack_seen)
    );

    // Full until the reader's acknowledge has come back through the synchronizer.
    assign full   = set_tog ^ ack_seen;
    assign accept = port_qualified(cs_n, en) && mbx_sel && !full;
    assign flag_n = !full;

    // Flip the set toggle once per accepted write.
    always_ff @(posedge clk) begin
        if (!clr_n)      set_tog <= 1'b0;
        else if (accept) set_tog <= ~set_tog;
    end

    // Load the mail word; only a master reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)      mail_q <= '0;
        else if (accept) mail_q <= data;
    end

    // R2: an accepted write leaves the flag low on the next cycle.
    a_r2_flag_after_write: assert property (@(posedge clk) disable iff (!clr_n)
        accept |=> !flag_n);

    // R3: no change to the mail word while a word is waiting.
    a_r3_hold_while_full: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_n |=> $stable(mail_q));

    // R4: an unqualified or non-mailbox write leaves the word alone.
    a_r4_unqualified_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !en || !mbx_sel) |=> $stable(mail_q));

    // R10: partial reset frees the write-side view.
    a_r10_prst_frees_wr: assert property (@(posedge clk) disable iff (!rst_n)
        !prst_n |=> flag_n);

endmodule

// File: rtl/mbx_rd_port.sv
// Module: read-domain half of the mailbox. Synchronizes the writer's set toggle,
// flips the acknowledge toggle on a mailbox read, and muxes the output bus.
// Assumes: mail_data is held stable by the write side while this side sees a word.
module mbx_rd_port
    import mbx_pkg::*;
#(
    parameter int unsigned WIDTH  = MBX_WIDTH_DEF,
    parameter int unsigned STAGES = MBX_SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prst_n,
    input  logic             cs_n,
    input  logic             en,
    input  logic             mbx_sel,
    input  logic             set_tog,
    input  logic [WIDTH-1:0] mail_data,
    input  logic [WIDTH-1:0] fifo_data,
    output logic             ack_tog,
    output logic             flag_n,
    output logic [WIDTH-1:0] rd_data
);

    logic clr_n;
    logic set_seen;
    logic full;
    logic take;

    assign clr_n = rst_n && prst_n;

    mbx_sync #(.STAGES(STAGES)) u_set_sync (
        .clk   (clk),
        .clr_n (clr_n),
        .d     (set_tog),
        .q     (set_seen)
    );

    // A word is waiting when the synchronized set toggle differs from the acknowledge.
    assign full   = set_seen ^ ack_tog;
    assign take   = port_qualified(cs_n, en) && mbx_sel && full;
    assign flag_n = !full;

    // Flip the acknowledge toggle once per mailbox read of a waiting word.
    always_ff @(posedge clk) begin
        if (!clr_n)    ack_tog <= 1'b0;
        else if (take) ack_tog <= ~ack_tog;
    end

    // Output steering between mail word and FIFO data.
    always_comb begin
        rd_data = mbx_sel ? mail_data : fifo_data;
    end

    // R7: a mailbox read of a waiting word frees the read-side view.
    a_r7_clear_on_read: assert property (@(posedge clk) disable iff (!clr_n)
        take |=> flag_n);

    // R8: without a mailbox read the waiting word stays flagged.
    a_r8_no_clear_otherwise: assert property (@(posedge clk) disable iff (!clr_n)
        (!flag_n && !take) |=> !flag_n);

    // R10: partial reset frees the read-side view.
    a_r10_prst_frees_rd: assert property (@(posedge clk) disable iff (!rst_n)
        !prst_n |=> flag_n);

endmodule

// File: rtl/mbx_bridge.sv
// Module: top of the cross-clock mailbox. Connects the write-domain and
// read-domain halves through the set and acknowledge toggles.
// Assumes: both domains receive each reset type together, held for at least
// STAGES+1 cycles of the slower clock.
module mbx_bridge
    import mbx_pkg::*;
#(
    parameter int unsigned WIDTH       = MBX_WIDTH_DEF,
    parameter int unsigned SYNC_STAGES = MBX_SYNC_DEF
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             wr_prst_n,
    input  logic             wr_cs_n,
    input  logic             wr_en,
    input  logic             wr_mbx_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_mail_flag_n,
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic             rd_prst_n,
    input  logic             rd_cs_n,
    input  logic             rd_en,
    input  logic             rd_mbx_sel,
    input  logic [WIDTH-1:0] fifo_data,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_mail_flag_n
);

    logic [WIDTH-1:0] mail_word;
    logic             set_tog;
    logic             ack_tog;

    mbx_wr_port #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_wr (
        .clk     (wr_clk),
        .rst_n   (wr_rst_n),
        .prst_n  (wr_prst_n),
        .cs_n    (wr_cs_n),
        .en      (wr_en),
        .mbx_sel (wr_mbx_sel),
        .data    (wr_data),
        .ack_tog (ack_tog),
        .mail_q  (mail_word),
        .set_tog (set_tog),
        .flag_n  (wr_mail_flag_n)
    );

    mbx_rd_port #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_rd (
        .clk       (rd_clk),
        .rst_n     (rd_rst_n),
        .prst_n    (rd_prst_n),
        .cs_n      (rd_cs_n),
        .en        (rd_en),
        .mbx_sel   (rd_mbx_sel),
        .set_tog   (set_tog),
        .mail_data (mail_word),
        .fifo_data (fifo_data),
        .ack_tog   (ack_tog),
        .flag_n    (rd_mail_flag_n),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/mbx_bridge_bench.sv
module mbx_bridge_bench;

    localparam int unsigned W = 36;
    localparam int unsigned S = 2;

    logic         wr_clk = 1'b0, rd_clk = 1'b0;
    logic         wr_rst_n = 1'b0, wr_prst_n = 1'b1, rd_rst_n = 1'b0, rd_prst_n = 1'b1;
    logic         wr_cs_n = 1'b1, wr_en = 1'b0, wr_mbx_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_cs_n = 1'b1, rd_en = 1'b0, rd_mbx_sel = 1'b1;
    logic [W-1:0] fifo_data = 36'h0F1F0_A5A5;
    logic [W-1:0] rd_data;
    logic         wr_mail_flag_n, rd_mail_flag_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    mbx_bridge #(.WIDTH(W), .SYNC_STAGES(S)) u_mbx_bridge (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_prst_n(wr_prst_n),
        .wr_cs_n(wr_cs_n), .wr_en(wr_en), .wr_mbx_sel(wr_mbx_sel),
        .wr_data(wr_data), .wr_mail_flag_n(wr_mail_flag_n),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_prst_n(rd_prst_n),
        .rd_cs_n(rd_cs_n), .rd_en(rd_en), .rd_mbx_sel(rd_mbx_sel),
        .fifo_data(fifo_data), .rd_data(rd_data), .rd_mail_flag_n(rd_mail_flag_n)
    );

    // 125 MHz on both sides; read clock rises 3 ns after the write clock.
    always #4 wr_clk = ~wr_clk;
    initial begin
        #7;
        forever begin
            rd_clk = ~rd_clk;
            #4;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_pulse(input logic cs_n, input logic en, input logic sel, input logic [W-1:0] d);
        @(negedge wr_clk);
        wr_cs_n = cs_n; wr_en = en; wr_mbx_sel = sel; wr_data = d;
        @(negedge wr_clk);
        wr_cs_n = 1'b1; wr_en = 1'b0; wr_mbx_sel = 1'b0;
    endtask

    task automatic rd_pulse(input logic cs_n, input logic en, input logic sel);
        @(negedge rd_clk);
        rd_cs_n = cs_n; rd_en = en; rd_mbx_sel = sel;
        @(negedge rd_clk);
        rd_cs_n = 1'b1; rd_en = 1'b0; rd_mbx_sel = 1'b1;
    endtask

    task automatic settle();
        repeat (S + 3) @(negedge rd_clk);
        repeat (S + 3) @(negedge wr_clk);
    endtask

    task automatic apply_reset(input bit master);
        @(negedge wr_clk);
        if (master) begin wr_rst_n = 1'b0; rd_rst_n = 1'b0; end
        else        begin wr_prst_n = 1'b0; rd_prst_n = 1'b0; end
        repeat (S + 2) @(negedge wr_clk);
        wr_rst_n = 1'b1; rd_rst_n = 1'b1; wr_prst_n = 1'b1; rd_prst_n = 1'b1;
        settle();
    endtask

    // Write a word and check both flag views, including the exact read-side edge.
    task automatic t_write(input logic [W-1:0] d);
        wr_pulse(1'b0, 1'b1, 1'b1, d);
        check("R2 wr flag low after write", wr_mail_flag_n, 0);
        repeat (S - 1) @(negedge rd_clk);
        check("R6 rd flag not yet low", rd_mail_flag_n, 1);
        @(negedge rd_clk);
        check("R6 rd flag low after sync", rd_mail_flag_n, 0);
        check("R1 mail word stored", rd_data, d);
    endtask

    task automatic t_reset_state();
        check("R10 wr flag high after master reset", wr_mail_flag_n, 1);
        check("R10 rd flag high after master reset", rd_mail_flag_n, 1);
        check("R10 mail cleared by master reset", rd_data, 0);
        rd_mbx_sel = 1'b0;
        #1;
        check("R5 fifo data with select low", rd_data, fifo_data);
        rd_mbx_sel = 1'b1;
    endtask

    task automatic t_blocked_write(input logic [W-1:0] keep, input logic [W-1:0] d);
        wr_pulse(1'b0, 1'b1, 1'b1, d);
        settle();
        check("R3 mail word kept while full", rd_data, keep);
        check("R3 wr flag still low", wr_mail_flag_n, 0);
        check("R3 rd flag still low", rd_mail_flag_n, 0);
    endtask

    task automatic t_non_clearing_reads(input logic [W-1:0] keep);
        rd_pulse(1'b0, 1'b1, 1'b0);
        check("R8 fifo read does not clear", rd_mail_flag_n, 0);
        rd_pulse(1'b1, 1'b1, 1'b1);
        check("R8 deselected read does not clear", rd_mail_flag_n, 0);
        rd_pulse(1'b0, 1'b0, 1'b1);
        check("R8 disabled read does not clear", rd_mail_flag_n, 0);
        rd_mbx_sel = 1'b0;
        #1;
        check("R5 fifo data while word waits", rd_data, fifo_data);
        rd_mbx_sel = 1'b1;
        #1;
        check("R5 mail data with select high", rd_data, keep);
    endtask

    // Clear by read, then try to write on the last edge of the guard window.
    task automatic t_clear_and_window(input logic [W-1:0] keep, input logic [W-1:0] d);
        rd_pulse(1'b0, 1'b1, 1'b1);
        check("R7 rd flag high after mailbox read", rd_mail_flag_n, 1);
        repeat (S - 1) @(negedge wr_clk);
        check("R9 wr flag still low in window", wr_mail_flag_n, 0);
        wr_cs_n = 1'b0; wr_en = 1'b1; wr_mbx_sel = 1'b1; wr_data = d;
        @(negedge wr_clk);
        wr_cs_n = 1'b1; wr_en = 1'b0; wr_mbx_sel = 1'b0;
        check("R9 wr flag high after sync", wr_mail_flag_n, 1);
        settle();
        check("R9 early write ignored, rd flag", rd_mail_flag_n, 1);
        check("R9 early write ignored, wr flag", wr_mail_flag_n, 1);
        check("R9 early write ignored, data", rd_data, keep);
    endtask

    task automatic t_unqualified(input logic [W-1:0] keep);
        wr_pulse(1'b1, 1'b1, 1'b1, 36'h111111111);
        wr_pulse(1'b0, 1'b0, 1'b1, 36'h222222222);
        wr_pulse(1'b0, 1'b1, 1'b0, 36'h333333333);
        settle();
        check("R4 wr flag unchanged", wr_mail_flag_n, 1);
        check("R4 rd flag unchanged", rd_mail_flag_n, 1);
        check("R4 mail word unchanged", rd_data, keep);
    endtask

    task automatic t_partial_reset(input logic [W-1:0] d);
        t_write(d);
        apply_reset(1'b0);
        check("R10 wr flag high after partial reset", wr_mail_flag_n, 1);
        check("R10 rd flag high after partial reset", rd_mail_flag_n, 1);
        check("R10 partial reset keeps word", rd_data, d);
    endtask

    task automatic t_master_reset(input logic [W-1:0] d);
        t_write(d);
        apply_reset(1'b1);
        check("R10 wr flag high after master reset", wr_mail_flag_n, 1);
        check("R10 rd flag high after master reset", rd_mail_flag_n, 1);
        check("R10 master reset clears word", rd_data, 0);
    endtask

    initial begin
        apply_reset(1'b1);
        t_reset_state();
        t_write(36'hABCDE_1234);
        t_blocked_write(36'hABCDE_1234, 36'h5_5555_5555);
        t_non_clearing_reads(36'hABCDE_1234);
        t_clear_and_window(36'hABCDE_1234, 36'h7_7777_7777);
        t_unqualified(36'hABCDE_1234);
        t_partial_reset(36'h8_0000_0001);
        t_master_reset(36'hF_FFFF_FFFF);
        t_write(36'h0_1357_9BDF);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge wr_clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule